// File: doc/BRIEF.md
# Fuse Shadow Register Bank

This block keeps a bank of 32-bit shadow copies of one-time-programmable fuse words and answers bus accesses to them. Shadow word `i` sits at bus byte offset `0x400 + 16*i`. Software reads its fuse configuration from the shadows rather than from the slow fuse array. It may also overwrite an unlocked shadow while the bank is idle.

A pulse on the reload request starts a sequencer. The sequencer walks the fuse array read port from word 0 upward, one address per cycle, and copies each returned word into its shadow. While this runs, `busy` is high. It drops, which also ends the request, as soon as the last word has landed.

Per-word lock vectors guard the bank. A read of a read-locked word returns the fixed pattern `0xBADABADA`. A write to a write-locked word, or any shadow write during a reload, is dropped. Each of these sets a sticky error flag. While that flag is set, reload requests are refused until software clears it.

Top module: `fuse_shadow_bank`

## Requirements
- R1: After reset every shadow word reads as zero, `busy` is 0 and `err_flag` is 0.
- R2: A bus read at offset `0x400 + 16*i`, with `i` below the word count, returns shadow word `i` on `bus_rdata` in the cycle after `bus_rd`. A read at any other offset returns zero and sets no error.
- R3: A bus write to an in-range offset whose word is not write-locked, issued while `busy` is 0, replaces that shadow word. The new value can be read back on the next access.
- R4: A read of a word whose `rd_lock` bit is 1 returns `0xBADABADA`, sets `err_flag` and leaves the shadow word intact.
- R5: A write to a word whose `wr_lock` bit is 1 is dropped and sets `err_flag`.
- R6: A bus write to any shadow while `busy` is 1 is dropped and sets `err_flag`. The word keeps its reloaded fuse value.
- R7: During a reload, `fuse_rd` is high for exactly one cycle per word, and `fuse_addr` runs 0, 1, … in ascending order. The word returned one cycle after each address lands in that address's shadow.
- R8: A reload request accepted at a clock edge raises `busy` at that edge. `busy` then stays high for exactly NWORDS+1 cycles before clearing by itself.
- R9: A reload request made while `err_flag` is 1 is refused, so `busy` stays 0. It is accepted once `err_flag` has been cleared through `err_clr`.
- R10: A reload request made while `busy` is 1 is ignored. The running sequence is neither restarted nor lengthened.
- R11: `err_flag` stays set until `err_clr` is pulsed. When a new error and `err_clr` occur in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Bus byte address |
| bus_rd | input | 1 | Bus read strobe |
| bus_wr | input | 1 | Bus write strobe |
| bus_wdata | input | 32 | Bus write data |
| bus_rdata | output | 32 | Registered read data |
| reload_req | input | 1 | Request a full reload from the fuse array |
| err_clr | input | 1 | Clears the error flag |
| rd_lock | input | NWORDS | Per-word read lock |
| wr_lock | input | NWORDS | Per-word write lock |
| fuse_rd | output | 1 | Fuse array read strobe |
| fuse_addr | output | IW | Fuse word address |
| fuse_rdata | input | 32 | Fuse word, valid one cycle after `fuse_rd` |
| busy | output | 1 | Reload in progress |
| err_flag | output | 1 | Sticky access error |

## Verification
A wrong sequencer count shows up in two ways: a `busy` pulse longer or shorter than NWORDS+1 cycles, or a word read back after the reload that disagrees with the fuse model. Both are visible within one reload. Mis-handled write gating shows at the next read of the same word, as a bus value where the fuse value was expected. A lost or stuck error flag appears on `err_flag` one cycle after the offending access, or as a refused or wrongly accepted reload at the following request.

// File: rtl/fsb_pkg.sv
package fsb_pkg;
  localparam int unsigned DW = 32;
  typedef logic [DW-1:0] word_t;
  localparam word_t LOCKED_PATTERN = 32'hBADA_BADA;
  localparam int unsigned BANK_BASE = 'h400;
  localparam int unsigned BANK_STRIDE_LOG2 = 4;
endpackage

// File: rtl/fsb_rst_sync.sv
module fsb_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/fsb_addr_dec.sv
module fsb_addr_dec #(
  parameter int unsigned AW     = 12,
  parameter int unsigned NWORDS = 64,
  parameter int unsigned IW     = 6
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [IW-1:0] idx
);
  import fsb_pkg::*;

  localparam logic [AW-1:0] BASE_A = AW'(BANK_BASE);
  localparam logic [AW-1:0] LIMIT  = AW'(NWORDS);

  logic [AW-1:0] off;

  always_comb begin
    off = addr - BASE_A;
    hit = (addr >= BASE_A) && (off[BANK_STRIDE_LOG2-1:0] == '0) &&
          ((off >> BANK_STRIDE_LOG2) < LIMIT);
    idx = off[IW+BANK_STRIDE_LOG2-1:BANK_STRIDE_LOG2];
  end
endmodule

// File: rtl/fsb_reload_seq.sv
module fsb_reload_seq #(
  parameter int unsigned NWORDS = 64,
  parameter int unsigned IW     = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic          issue,
  output logic [IW-1:0] rd_addr,
  output logic          ld_en,
  output logic [IW-1:0] ld_idx
);
  localparam logic [IW-1:0] LAST = IW'(NWORDS - 1);

  logic          busy_d, issue_d, ld_en_d;
  logic [IW-1:0] cnt_d, ld_idx_d;
  logic [IW-1:0] cnt_q;

  always_comb begin
    busy_d   = busy;
    issue_d  = issue;
    cnt_d    = cnt_q;
    ld_en_d  = issue;
    ld_idx_d = cnt_q;
    if (!busy && start) begin
      busy_d  = 1'b1;
      issue_d = 1'b1;
      cnt_d   = '0;
    end else if (busy) begin
      if (issue) begin
        if (cnt_q == LAST) issue_d = 1'b0;
        else               cnt_d   = cnt_q + 1'b1;
      end
      if (ld_en && ld_idx == LAST) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      issue  <= 1'b0;
      cnt_q  <= '0;
      ld_en  <= 1'b0;
      ld_idx <= '0;
    end else begin
      busy   <= busy_d;
      issue  <= issue_d;
      cnt_q  <= cnt_d;
      ld_en  <= ld_en_d;
      ld_idx <= ld_idx_d;
    end
  end

  assign rd_addr = cnt_q;
endmodule

// File: rtl/fsb_err_flag.sv
module fsb_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_d;

  always_comb begin
    flag_d = flag;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_d;
  end
endmodule

// File: rtl/fuse_shadow_bank.sv
module fuse_shadow_bank #(
  parameter int unsigned NWORDS = 64,
  parameter int unsigned AW     = 12,
  localparam int unsigned IW    = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              reload_req,
  input  logic              err_clr,
  input  logic [NWORDS-1:0] rd_lock,
  input  logic [NWORDS-1:0] wr_lock,
  output logic              fuse_rd,
  output logic [IW-1:0]     fuse_addr,
  input  logic [31:0]       fuse_rdata,
  output logic              busy,
  output logic              err_flag
);
  import fsb_pkg::*;

  logic          rst_ns;
  logic          hit;
  logic [IW-1:0] idx;
  logic          ld_en;
  logic [IW-1:0] ld_idx;
  logic          wr_ok, err_set;
  logic          rdata_en;
  word_t         rdata_d;
  word_t         shadow_q [NWORDS];

  fsb_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  fsb_addr_dec #(.AW(AW), .NWORDS(NWORDS), .IW(IW)) u_dec (
    .addr(bus_addr), .hit(hit), .idx(idx)
  );

  fsb_reload_seq #(.NWORDS(NWORDS), .IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_ns), .start(reload_req && !err_flag),
    .busy(busy), .issue(fuse_rd), .rd_addr(fuse_addr),
    .ld_en(ld_en), .ld_idx(ld_idx)
  );

  always_comb begin
    wr_ok   = bus_wr && hit && !busy && !wr_lock[idx];
    err_set = (bus_wr && hit && (busy || wr_lock[idx])) ||
              (bus_rd && hit && rd_lock[idx]);
    rdata_en = bus_rd;
    if (!hit)              rdata_d = '0;
    else if (rd_lock[idx]) rdata_d = LOCKED_PATTERN;
    else                   rdata_d = shadow_q[idx];
  end

  fsb_err_flag u_err (
    .clk(clk), .rst_n(rst_ns), .set(err_set), .clr(err_clr), .flag(err_flag)
  );

  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    logic  en;
    word_t d;
    always_comb begin
      en = 1'b0;
      d  = shadow_q[g];
      if (ld_en && ld_idx == IW'(g)) begin
        en = 1'b1;
        d  = fuse_rdata;
      end else if (wr_ok && idx == IW'(g)) begin
        en = 1'b1;
        d  = bus_wdata;
      end
    end
    always_ff @(posedge clk or negedge rst_ns) begin
      if (!rst_ns)  shadow_q[g] <= '0;
      else if (en)  shadow_q[g] <= d;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns)       bus_rdata <= '0;
    else if (rdata_en) bus_rdata <= rdata_d;
  end
endmodule

// File: rtl/fuse_shadow_bank_chk.sv
module fuse_shadow_bank_chk #(
  parameter int unsigned NWORDS = 64,
  localparam int unsigned IW    = $clog2(NWORDS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reload_req,
  input logic          err_clr,
  input logic          busy,
  input logic          err_flag,
  input logic          fuse_rd,
  input logic [IW-1:0] fuse_addr
);
  // R7: fuse addresses climb by one on consecutive reads
  a_r7_addr_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd && $past(fuse_rd) |-> fuse_addr == $past(fuse_addr) + 1'b1);

  // R7: the fuse array is only read during a reload
  a_r7_read_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    fuse_rd |-> busy);

  // R8: an accepted request starts at word 0
  a_r8_start_word0: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !err_flag && reload_req |=> busy && fuse_rd && fuse_addr == '0);

  // R9: no start while the error flag is up
  a_r9_refused_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && err_flag && reload_req |=> !busy);

  // R11: the error flag only falls through err_clr
  a_r11_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag && !err_clr |=> err_flag);
endmodule

bind fuse_shadow_bank fuse_shadow_bank_chk #(.NWORDS(NWORDS)) u_chk (
  .clk(clk), .rst_n(rst_n), .reload_req(reload_req), .err_clr(err_clr),
  .busy(busy), .err_flag(err_flag), .fuse_rd(fuse_rd), .fuse_addr(fuse_addr)
);

// File: tb/sim_fuse_shadow_bank.sv
`timescale 1ns/1ps
module sim_fuse_shadow_bank;
  localparam int N  = 64;
  localparam int AW = 12;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] bus_addr;
  logic          bus_rd, bus_wr, reload_req, err_clr;
  logic [31:0]   bus_wdata, bus_rdata, fuse_rdata;
  logic [N-1:0]  rd_lock, wr_lock;
  logic          fuse_rd, busy, err_flag;
  logic [IW-1:0] fuse_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;
  logic [31:0] sh_m [N];
  bit err_m;

  always #5 clk = ~clk;

  fuse_shadow_bank #(.NWORDS(N), .AW(AW)) u0 (.*);

  function automatic logic [31:0] fuse_fn(input logic [IW-1:0] a);
    return (32'(a) * 32'h0101_0101) ^ 32'hC3A5_0000;
  endfunction

  function automatic logic [AW-1:0] waddr(input int i);
    return AW'('h400 + 16 * i);
  endfunction

  always @(posedge clk) if (fuse_rd) fuse_rdata <= fuse_fn(fuse_addr);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick; @(negedge clk); endtask

  task automatic rd(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    bus_addr = a; bus_rd = 1'b1; tick; bus_rd = 1'b0;
    chk(req, bus_rdata, exp);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; tick; bus_wr = 1'b0;
  endtask

  task automatic clr_err;
    err_clr = 1'b1; tick; err_clr = 1'b0; err_m = 0;
  endtask

  // Returns number of sampled busy cycles; optional mid-run write and re-request
  task automatic reload(input int wr_at, input int req_at, output int len);
    reload_req = 1'b1; tick; reload_req = 1'b0;
    len = 0;
    while (busy && len < 4 * N) begin
      if (len == wr_at) begin bus_addr = waddr(0); bus_wdata = 32'hDEAD_0000; bus_wr = 1'b1; end
      if (len == req_at) reload_req = 1'b1;
      len++;
      tick;
      bus_wr = 1'b0; reload_req = 1'b0;
    end
    for (int i = 0; i < N; i++) sh_m[i] = fuse_fn(IW'(i));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int len;
    void'($urandom(32'h1234));
    rst_n = 1'b0; bus_addr = '0; bus_rd = 0; bus_wr = 0; bus_wdata = '0;
    reload_req = 0; err_clr = 0; rd_lock = '0; wr_lock = '0; err_m = 0;
    repeat (3) tick;
    rst_n = 1'b1;
    repeat (4) tick;

    // R1: reset state
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 err", {31'b0, err_flag}, 32'd0);
    rd(waddr(0), 32'h0, "R1 word0");
    rd(waddr(N-1), 32'h0, "R1 last word");

    // R3: idle unlocked write
    wr(waddr(5), 32'h1111_2222);
    rd(waddr(5), 32'h1111_2222, "R3 readback");

    // R8 R10: reload length with a second request mid-run
    reload(-1, 10, len);
    chk("R8 R10 busy length", len, N + 1);
    // R7: every word holds its fuse value after reload
    for (int i = 0; i < N; i += 9) rd(waddr(i), fuse_fn(IW'(i)), "R7 loaded word");
    rd(waddr(N-1), fuse_fn(IW'(N-1)), "R7 last word");

    // R2: out-of-map reads
    rd(AW'('h404), 32'h0, "R2 misaligned");
    rd(AW'('h100), 32'h0, "R2 below base");
    rd(AW'('h400 + 16 * N), 32'h0, "R2 past end");
    chk("R2 no error", {31'b0, err_flag}, 32'd0);

    // R6: write during reload dropped and flagged
    reload(N / 2, -1, len);
    chk("R6 error", {31'b0, err_flag}, 32'd1);
    rd(waddr(0), fuse_fn(IW'(0)), "R6 word0 unchanged");

    // R9: refused while error set
    reload_req = 1'b1; tick; reload_req = 1'b0;
    chk("R9 refused", {31'b0, busy}, 32'd0);
    clr_err;
    chk("R11 cleared", {31'b0, err_flag}, 32'd0);
    reload(-1, -1, len);
    chk("R9 accepted after clear", len, N + 1);

    // R11: set wins over clear in same cycle
    rd_lock[3] = 1'b1;
    bus_addr = waddr(3); bus_rd = 1'b1; err_clr = 1'b1; tick; bus_rd = 0; err_clr = 0;
    chk("R11 set wins", {31'b0, err_flag}, 32'd1);
    chk("R4 pattern", bus_rdata, 32'hBADA_BADA);
    tick;
    chk("R11 sticky", {31'b0, err_flag}, 32'd1);
    clr_err; rd_lock = '0;
    rd(waddr(3), fuse_fn(IW'(3)), "R4 shadow intact");

    // Random mix of accesses with random locks (R3 R4 R5)
    for (int k = 0; k < 400; k++) begin
      int i = int'($urandom_range(N - 1, 0));
      logic [31:0] d = $urandom;
      rd_lock = {$urandom, $urandom};
      wr_lock = {$urandom, $urandom};
      if ($urandom_range(7, 0) == 0) clr_err;
      if ($urandom_range(1, 0) == 1) begin
        wr(waddr(i), d);
        if (wr_lock[i]) err_m = 1; else sh_m[i] = d;
        chk("R5 R3 error after write", {31'b0, err_flag}, {31'b0, err_m});
      end else begin
        rd(waddr(i), rd_lock[i] ? 32'hBADA_BADA : sh_m[i], "R4 R2 random read");
        if (rd_lock[i]) err_m = 1;
        chk("R4 error after read", {31'b0, err_flag}, {31'b0, err_m});
      end
    end
    rd_lock = '0;
    for (int i = 0; i < N; i++) rd(waddr(i), sh_m[i], "R5 R3 final contents");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule